// File: doc/BRIEF.md
# Card ROM Block Transfer Controller

This controller lets software pull blocks of data out of a cartridge ROM through a small register window. Software first writes an eight-byte command into two command words. It then writes the control word with its start flag set. When the command opcode is the block-read code, the controller takes a 32-bit start address from the command and starts fetching 32-bit words from a ROM-side read port. The block length comes from a coded size field. One fetched word is held in a single-word buffer. Each read of the data port returns that word and starts the fetch of the next one, until the block is used up.

Two processor ports share the window, but only one of them owns the card bus at a time. An external-memory configuration value selects the owner. Accesses from the other port are ignored, apart from reads of the control word, which both ports see identically. The ROM side uses a request/ready address handshake and a separate valid strobe for the returned word, so its latency can vary. While a fetch is in flight, the owner's data-port reads and control-word writes are held off by withholding the acknowledge.

Top module: `card_rom_xfer`

## Requirements
- R1: After reset the control word reads 0, the data port reads 0, `rom_req` is low, the configuration output reads 0x0800 and port A owns the card bus.
- R2: The register window is selected by a 2-bit word index: 0 is control, 1 is command bytes 0..3, 2 is command bytes 4..7, and 3 is the data port. Within a command word, byte k sits at bits 8k+7:8k. Both command words read back as written. Control bits 31 (busy) and 23 (word ready) read the engine status and ignore written values. All other control bits read back as written.
- R3: Control bits 26:24 code the block length. Code 0 gives no data words. Codes 1..6 give 256<<code bytes. Code 7 gives exactly one 4-byte word.
- R4: A control write with bit 31 set and command byte 0 equal to 0xB7 sets busy. It then fetches the first word from the address formed by command bytes 1,2,3,4, most significant byte first. Each later fetch uses the previous address plus 4.
- R5: A start with any other opcode, or with size code 0, leaves busy and word ready clear immediately and issues no ROM fetch.
- R6: Each data-port read returns the buffered word and then fetches the next one. The read that returns the last word of the block also clears busy, word ready and the buffer, so later data reads return 0.
- R7: Word ready is low while a fetch is outstanding and rises when the returned word is captured. `rom_req` stays high with a stable `rom_addr` until `rom_ready` accepts it.
- R8: An owner data-port read made while a fetch is outstanding is not acknowledged until the word arrives, and it then returns the new word.
- R9: A configuration write stores its value masked with 0xE8FF. When bit 11 of the stored value is set, port A owns the card bus; when it is clear, port B owns it.
- R10: On the non-owning port, writes change nothing, command and data reads return 0, and data reads do not advance the transfer. Its control reads return the same status the owner sees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | External-memory configuration write strobe |
| cfg_wdata | input | 16 | Configuration value to store |
| cfg_q | output | 16 | Stored, masked configuration value |
| pa_req | input | 1 | Port A access request, held until acknowledged |
| pa_we | input | 1 | Port A write enable |
| pa_addr | input | 2 | Port A register word index |
| pa_wdata | input | 32 | Port A write data |
| pa_ack | output | 1 | Port A access completes on this clock edge |
| pa_rdata | output | 32 | Port A read data, valid with ack |
| pb_req | input | 1 | Port B access request, held until acknowledged |
| pb_we | input | 1 | Port B write enable |
| pb_addr | input | 2 | Port B register word index |
| pb_wdata | input | 32 | Port B write data |
| pb_ack | output | 1 | Port B access completes on this clock edge |
| pb_rdata | output | 32 | Port B read data, valid with ack |
| rom_req | output | 1 | ROM word fetch request |
| rom_addr | output | 32 | ROM byte address of the fetch |
| rom_ready | input | 1 | ROM accepts the request |
| rom_rvalid | input | 1 | ROM returns the fetched word |
| rom_rdata | input | 32 | Fetched ROM word |

## Verification
The bench builds the block with the package defaults: a 15-bit byte counter that covers the longest coded block of 16384 bytes. The ROM model adds a random latency of 0 to 3 cycles and throttles its ready signal at random. This exercises the one-word length of code 7, the empty code 0, blocks of 128 and 256 words from codes 1 and 2, stalled reads and a held request. Ownership is moved to port B and back, so the gating rules are checked from both sides of the same transfer.

// File: rtl/card_pkg.sv
package card_pkg;

    localparam int WORD_W       = 32;
    localparam int HALF_W       = 16;
    localparam int SIZE_LSB     = 24;
    localparam int SIZE_W       = 3;
    localparam int READY_BIT    = 23;
    localparam int BUSY_BIT     = 31;
    localparam int OWN_BIT      = 11;
    localparam int MAX_SHIFT    = 6;
    localparam int BASE_BYTES   = 256;
    localparam int LEN_W        = 8 + MAX_SHIFT + 1;
    localparam int BYTES_PER_WD = WORD_W / 8;

    localparam logic [7:0]        OP_BLOCK_READ = 8'hB7;
    localparam logic [HALF_W-1:0] XCFG_MASK     = 16'hE8FF;
    localparam logic [HALF_W-1:0] XCFG_RESET    = 16'h0800;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_CMD_LO = 2'd1,
        SEL_CMD_HI = 2'd2,
        SEL_DATA   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_REQ  = 2'd1,
        ENG_WAIT = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic              fire;
        logic              we;
        reg_sel_e          sel;
        logic [WORD_W-1:0] wdata;
    } bus_acc_t;

    function automatic logic [LEN_W-1:0] block_bytes(input logic [SIZE_W-1:0] code);
        logic [LEN_W-1:0] len;
        case (code)
            3'd0:    len = '0;
            3'd7:    len = LEN_W'(BYTES_PER_WD);
            default: len = LEN_W'(BASE_BYTES) << code;
        endcase
        return len;
    endfunction

    function automatic logic [WORD_W-1:0] cmd_address(input logic [WORD_W-1:0] lo,
                                                      input logic [WORD_W-1:0] hi);
        return {lo[15:8], lo[23:16], lo[31:24], hi[7:0]};
    endfunction

endpackage

// File: rtl/card_port_arb.sv
module card_port_arb
    import card_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [HALF_W-1:0] cfg_wdata,
    output logic [HALF_W-1:0] cfg_q,
    input  logic              pa_req,
    input  logic              pa_we,
    input  logic [1:0]        pa_addr,
    input  logic [WORD_W-1:0] pa_wdata,
    output logic              pa_ack,
    output logic [WORD_W-1:0] pa_rdata,
    input  logic              pb_req,
    input  logic              pb_we,
    input  logic [1:0]        pb_addr,
    input  logic [WORD_W-1:0] pb_wdata,
    output logic              pb_ack,
    output logic [WORD_W-1:0] pb_rdata,
    input  logic              fetching,
    input  logic [WORD_W-1:0] status_word,
    input  logic [WORD_W-1:0] owner_rdata,
    output bus_acc_t          acc,
    output logic              owner_a
);

    logic [HALF_W-1:0] cfg_r;
    logic              own_req, own_we, stall;
    reg_sel_e          own_sel, sel_a, sel_b;
    logic [WORD_W-1:0] own_wdata;

    always_ff @(posedge clk) begin
        if (rst)         cfg_r <= XCFG_RESET;
        else if (cfg_we) cfg_r <= cfg_wdata & XCFG_MASK;
    end

    assign cfg_q   = cfg_r;
    assign owner_a = cfg_r[OWN_BIT];
    assign sel_a   = reg_sel_e'(pa_addr);
    assign sel_b   = reg_sel_e'(pb_addr);

    always_comb begin
        own_req   = owner_a ? pa_req   : pb_req;
        own_we    = owner_a ? pa_we    : pb_we;
        own_sel   = owner_a ? sel_a    : sel_b;
        own_wdata = owner_a ? pa_wdata : pb_wdata;
        stall     = fetching && ((own_sel == SEL_DATA && !own_we) ||
                                 (own_sel == SEL_CTRL &&  own_we));
        acc.fire  = own_req && !stall;
        acc.we    = own_we;
        acc.sel   = own_sel;
        acc.wdata = own_wdata;
    end

    always_comb begin
        if (owner_a) begin
            pa_ack   = pa_req && !stall;
            pa_rdata = owner_rdata;
            pb_ack   = pb_req;
            pb_rdata = (sel_b == SEL_CTRL) ? status_word : '0;
        end else begin
            pb_ack   = pb_req && !stall;
            pb_rdata = owner_rdata;
            pa_ack   = pa_req;
            pa_rdata = (sel_a == SEL_CTRL) ? status_word : '0;
        end
    end

    assert_nonowner_a_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!owner_a && pa_req && sel_a != SEL_CTRL) |-> (pa_rdata == '0));

    assert_nonowner_b_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (owner_a && pb_req && sel_b != SEL_CTRL) |-> (pb_rdata == '0));

    assert_cfg_masked_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == ($past(cfg_wdata) & XCFG_MASK)));

endmodule

// File: rtl/card_regs.sv
module card_regs
    import card_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_acc_t          acc,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] cmd_lo,
    output logic [WORD_W-1:0] cmd_hi,
    output logic              start,
    output logic [SIZE_W-1:0] start_code,
    output logic              pop
);

    logic [WORD_W-1:0] ctrl_r, lo_r, hi_r;
    logic              wr_fire;

    assign wr_fire = acc.fire && acc.we;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= '0;
            lo_r   <= '0;
            hi_r   <= '0;
        end else if (wr_fire) begin
            case (acc.sel)
                SEL_CTRL: begin
                    ctrl_r            <= acc.wdata;
                    ctrl_r[READY_BIT] <= 1'b0;
                    ctrl_r[BUSY_BIT]  <= 1'b0;
                end
                SEL_CMD_LO: lo_r <= acc.wdata;
                SEL_CMD_HI: hi_r <= acc.wdata;
                default: ;
            endcase
        end
    end

    assign ctrl_q     = ctrl_r;
    assign cmd_lo     = lo_r;
    assign cmd_hi     = hi_r;
    assign start      = wr_fire && acc.sel == SEL_CTRL && acc.wdata[BUSY_BIT];
    assign start_code = acc.wdata[SIZE_LSB +: SIZE_W];
    assign pop        = acc.fire && !acc.we && acc.sel == SEL_DATA;

    assert_status_bits_clear_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (!ctrl_r[READY_BIT] && !ctrl_r[BUSY_BIT]));

endmodule

// File: rtl/card_xfer_engine.sv
module card_xfer_engine
    import card_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SIZE_W-1:0] start_code,
    input  logic [7:0]        opcode,
    input  logic [WORD_W-1:0] start_addr,
    input  logic              pop,
    output logic              busy,
    output logic              ready,
    output logic [WORD_W-1:0] buffer,
    output logic              fetching,
    output logic              rom_req,
    output logic [WORD_W-1:0] rom_addr,
    input  logic              rom_ready,
    input  logic              rom_rvalid,
    input  logic [WORD_W-1:0] rom_rdata
);

    eng_state_e        state;
    logic [LEN_W-1:0]  remaining, start_len;
    logic [WORD_W-1:0] next_addr, fetch_addr, buf_r;
    logic              busy_r, ready_r, go;

    assign start_len = block_bytes(start_code);
    assign go        = (opcode == OP_BLOCK_READ) && (start_len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            remaining  <= '0;
            next_addr  <= '0;
            fetch_addr <= '0;
            buf_r      <= '0;
            busy_r     <= 1'b0;
            ready_r    <= 1'b0;
        end else if (start) begin
            ready_r <= 1'b0;
            buf_r   <= '0;
            if (go) begin
                busy_r     <= 1'b1;
                fetch_addr <= start_addr;
                next_addr  <= start_addr + WORD_W'(BYTES_PER_WD);
                remaining  <= start_len - LEN_W'(BYTES_PER_WD);
                state      <= ENG_REQ;
            end else begin
                busy_r    <= 1'b0;
                remaining <= '0;
                state     <= ENG_IDLE;
            end
        end else if (pop) begin
            ready_r <= 1'b0;
            if (remaining != '0) begin
                fetch_addr <= next_addr;
                next_addr  <= next_addr + WORD_W'(BYTES_PER_WD);
                remaining  <= remaining - LEN_W'(BYTES_PER_WD);
                state      <= ENG_REQ;
            end else begin
                buf_r  <= '0;
                busy_r <= 1'b0;
            end
        end else begin
            case (state)
                ENG_REQ:  if (rom_ready) state <= ENG_WAIT;
                ENG_WAIT: if (rom_rvalid) begin
                    buf_r   <= rom_rdata;
                    ready_r <= 1'b1;
                    state   <= ENG_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign busy     = busy_r;
    assign ready    = ready_r;
    assign buffer   = buf_r;
    assign fetching = (state != ENG_IDLE);
    assign rom_req  = (state == ENG_REQ);
    assign rom_addr = fetch_addr;

    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        (rom_req && !rom_ready) |=> (rom_req && $stable(rom_addr)));

    assert_ready_on_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_WAIT && rom_rvalid && !start && !pop) |=> (ready && buffer == $past(rom_rdata)));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (pop && remaining != '0) |=> (rom_req && rom_addr == $past(rom_addr) + WORD_W'(BYTES_PER_WD)));

    assert_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && remaining == '0) |=> (!busy && !ready && buffer == '0));

    assert_no_pop_in_flight_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> (state == ENG_IDLE));

    assert_other_op_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (start && opcode != OP_BLOCK_READ) |=> (!busy && !rom_req));

endmodule

// File: rtl/card_rom_xfer.sv
module card_rom_xfer
    import card_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_q,
    input  logic        pa_req,
    input  logic        pa_we,
    input  logic [1:0]  pa_addr,
    input  logic [31:0] pa_wdata,
    output logic        pa_ack,
    output logic [31:0] pa_rdata,
    input  logic        pb_req,
    input  logic        pb_we,
    input  logic [1:0]  pb_addr,
    input  logic [31:0] pb_wdata,
    output logic        pb_ack,
    output logic [31:0] pb_rdata,
    output logic        rom_req,
    output logic [31:0] rom_addr,
    input  logic        rom_ready,
    input  logic        rom_rvalid,
    input  logic [31:0] rom_rdata
);

    bus_acc_t          acc;
    logic              owner_a, fetching, busy, ready, start, pop;
    logic [WORD_W-1:0] ctrl_q, cmd_lo, cmd_hi, buffer, status_word, owner_rdata;
    logic [SIZE_W-1:0] start_code;

    card_port_arb u_arb (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .pa_req(pa_req), .pa_we(pa_we), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
        .pa_ack(pa_ack), .pa_rdata(pa_rdata),
        .pb_req(pb_req), .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_ack(pb_ack), .pb_rdata(pb_rdata),
        .fetching(fetching), .status_word(status_word), .owner_rdata(owner_rdata),
        .acc(acc), .owner_a(owner_a)
    );

    card_regs u_regs (
        .clk(clk), .rst(rst), .acc(acc),
        .ctrl_q(ctrl_q), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
        .start(start), .start_code(start_code), .pop(pop)
    );

    card_xfer_engine u_eng (
        .clk(clk), .rst(rst),
        .start(start), .start_code(start_code),
        .opcode(cmd_lo[7:0]), .start_addr(cmd_address(cmd_lo, cmd_hi)),
        .pop(pop), .busy(busy), .ready(ready), .buffer(buffer), .fetching(fetching),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_ready(rom_ready),
        .rom_rvalid(rom_rvalid), .rom_rdata(rom_rdata)
    );

    always_comb begin
        status_word            = ctrl_q;
        status_word[BUSY_BIT]  = busy;
        status_word[READY_BIT] = ready;
        case (acc.sel)
            SEL_CTRL:   owner_rdata = status_word;
            SEL_CMD_LO: owner_rdata = cmd_lo;
            SEL_CMD_HI: owner_rdata = cmd_hi;
            default:    owner_rdata = buffer;
        endcase
    end

    assert_fetch_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
        rom_req |-> busy);

    assert_one_owner_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (owner_a && pb_req) |-> pb_ack);

endmodule

// File: tb/card_rom_xfer_tb.sv
module card_rom_xfer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic        pa_req = 1'b0, pa_we = 1'b0;
    logic [1:0]  pa_addr = '0;
    logic [31:0] pa_wdata = '0;
    logic        pa_ack;
    logic [31:0] pa_rdata;
    logic        pb_req = 1'b0, pb_we = 1'b0;
    logic [1:0]  pb_addr = '0;
    logic [31:0] pb_wdata = '0;
    logic        pb_ack;
    logic [31:0] pb_rdata;
    logic        rom_req;
    logic [31:0] rom_addr;
    logic        rom_ready = 1'b0, rom_rvalid = 1'b0;
    logic [31:0] rom_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int hold_ready = 0, force_lat = 0;
    int acc_cnt = 0;
    logic        acc_flag = 1'b0;
    logic [31:0] acc_addr = '0;

    always #5 clk = ~clk;

    card_rom_xfer u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .pa_req(pa_req), .pa_we(pa_we), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
        .pa_ack(pa_ack), .pa_rdata(pa_rdata),
        .pb_req(pb_req), .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_ack(pb_ack), .pb_rdata(pb_rdata),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_ready(rom_ready),
        .rom_rvalid(rom_rvalid), .rom_rdata(rom_rdata)
    );

    function automatic logic [31:0] rom_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
    endfunction

    function automatic int block_words(input int code);
        if (code == 0) return 0;
        if (code == 7) return 1;
        return (256 << code) / 4;
    endfunction

    always @(posedge clk) begin
        if (rom_req && rom_ready) begin
            acc_flag <= 1'b1;
            acc_addr <= rom_addr;
            acc_cnt  <= acc_cnt + 1;
        end else begin
            acc_flag <= 1'b0;
        end
    end

    initial begin : rom_model
        logic        outst;
        int          lat;
        logic [31:0] o_addr;
        outst = 1'b0; lat = 0; o_addr = '0;
        forever begin
            @(negedge clk);
            rom_rvalid = 1'b0;
            if (outst) begin
                if (lat == 0) begin
                    rom_rvalid = 1'b1;
                    rom_rdata  = rom_word(o_addr);
                    outst      = 1'b0;
                end else begin
                    lat = lat - 1;
                end
            end
            if (acc_flag) begin
                outst  = 1'b1;
                o_addr = acc_addr;
                lat    = (force_lat > 0) ? force_lat : int'($urandom_range(0, 3));
                force_lat = 0;
            end
            if (hold_ready > 0) begin
                rom_ready  = 1'b0;
                hold_ready = hold_ready - 1;
            end else begin
                rom_ready = 1'($urandom_range(0, 1));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input int port, input bit we, input logic [1:0] sel,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
        if (port == 0) begin
            pa_req = 1'b1; pa_we = we; pa_addr = sel; pa_wdata = wd;
        end else begin
            pb_req = 1'b1; pb_we = we; pb_addr = sel; pb_wdata = wd;
        end
        waits = 0;
        forever begin
            #1;
            if ((port == 0) ? pa_ack : pb_ack) break;
            waits++;
            if (waits > 2000) break;
            @(negedge clk);
        end
        rd = (port == 0) ? pa_rdata : pb_rdata;
        @(negedge clk);
        if (port == 0) pa_req = 1'b0; else pb_req = 1'b0;
    endtask

    task automatic wr(input int port, input logic [1:0] sel, input logic [31:0] wd);
        logic [31:0] rd;
        int w;
        access(port, 1'b1, sel, wd, rd, w);
    endtask

    task automatic rd_reg(input int port, input logic [1:0] sel, output logic [31:0] rd);
        int w;
        access(port, 1'b0, sel, '0, rd, w);
    endtask

    task automatic set_cfg(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_cmd(input int port, input logic [7:0] op, input logic [31:0] sa);
        wr(port, 2'd1, {sa[15:8], sa[23:16], sa[31:24], op});
        wr(port, 2'd2, {$urandom_range(0, 32'hFFFF), 8'h00, sa[7:0]});
    endtask

    task automatic run_block(input int port, input int code, input logic [7:0] op,
                             input logic [31:0] sa, input string tag);
        logic [31:0] v;
        int n, a0;
        n  = (op == 8'hB7) ? block_words(code) : 0;
        load_cmd(port, op, sa);
        a0 = acc_cnt;
        wr(port, 2'd0, 32'h8000_0000 | (32'(code) << 24) | 32'h0000_00A5);
        if (n == 0) begin
            rd_reg(port, 2'd0, v);
            chk({tag, " R5 no-data start leaves busy/ready clear"}, {31'd0, v[31]} | {31'd0, v[23]}, 32'd0);
            repeat (4) @(negedge clk);
            chk({tag, " R5 no ROM fetch"}, 32'(acc_cnt - a0), 32'd0);
        end else begin
            rd_reg(port, 2'd0, v);
            chk({tag, " R4 busy after start"}, {31'd0, v[31]}, 32'd1);
            for (int i = 0; i < n; i++) begin
                rd_reg(port, 2'd3, v);
                chk({tag, " R4 R6 data word"}, v, rom_word(sa + 32'(4 * i)));
            end
            rd_reg(port, 2'd0, v);
            chk({tag, " R6 busy/ready clear after last word"}, {31'd0, v[31]} | {31'd0, v[23]}, 32'd0);
            chk({tag, " R3 fetch count equals block length"}, 32'(acc_cnt - a0), 32'(n));
            rd_reg(port, 2'd3, v);
            chk({tag, " R6 data reads 0 after block"}, v, 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v, w2, sa;
        int waits, codes[4];
        void'($urandom(32'd4242));
        codes[0] = 0; codes[1] = 1; codes[2] = 2; codes[3] = 7;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rom_req low", {31'd0, rom_req}, 32'd0);
        chk("R1 cfg reset", {16'd0, cfg_q}, 32'h0000_0800);
        rd_reg(0, 2'd0, v); chk("R1 control reads 0", v, 32'd0);
        rd_reg(0, 2'd3, v); chk("R1 data reads 0", v, 32'd0);

        // R2 register map and read-back
        wr(0, 2'd1, 32'h1122_3344); wr(0, 2'd2, 32'h5566_7788);
        rd_reg(0, 2'd1, v); chk("R2 cmd lo read-back", v, 32'h1122_3344);
        rd_reg(0, 2'd2, v); chk("R2 cmd hi read-back", v, 32'h5566_7788);
        wr(0, 2'd0, 32'h7F8F_1234);
        rd_reg(0, 2'd0, v); chk("R2 control bits 23/31 from status", v, 32'h7F0F_1234);

        // R3 R4 R6 directed sizes
        run_block(0, 7, 8'hB7, 32'h0000_4000, "code7");
        run_block(0, 0, 8'hB7, 32'h0000_8000, "code0");
        run_block(0, 1, 8'hB7, 32'h0123_4560, "code1");
        // R5 other opcode
        run_block(0, 1, 8'h3C, 32'h0000_1000, "op3C");

        // R7 held request, R8 stalled read
        sa = 32'hA5A5_0100;
        load_cmd(0, 8'hB7, sa);
        hold_ready = 6;
        wr(0, 2'd0, 32'h8700_0000);
        #1;
        chk("R7 rom_req held", {31'd0, rom_req}, 32'd1);
        chk("R7 rom_addr is start address", rom_addr, sa);
        @(negedge clk);
        rd_reg(0, 2'd0, v);
        chk("R7 ready low while outstanding", {31'd0, v[23]}, 32'd0);
        #1;
        chk("R7 rom_addr stable", rom_addr, sa);
        force_lat = 5;
        @(negedge clk);
        access(0, 1'b0, 2'd3, '0, v, waits);
        chk("R8 stalled read returns new word", v, rom_word(sa));
        chk("R8 read was held off", {31'd0, waits >= 3}, 32'd1);
        rd_reg(0, 2'd0, v);
        chk("R6 single word block done", {31'd0, v[31]}, 32'd0);

        // Random transfers on port A
        for (int t = 0; t < 6; t++) begin
            int c;
            c  = codes[$urandom_range(0, 3)];
            sa = {$urandom_range(0, 32'hFFFF), 14'($urandom_range(0, 16'h3FFF)), 2'b00};
            run_block(0, c, 8'hB7, sa, "rand");
        end

        // R9 ownership and masking
        set_cfg(16'hFFFF);
        chk("R9 cfg masked", {16'd0, cfg_q}, 32'h0000_E8FF);
        set_cfg(16'h07FF);
        chk("R9 cfg masked owner B", {16'd0, cfg_q}, 32'h0000_00FF);
        run_block(1, 7, 8'hB7, 32'h0000_2220, "portB");

        // R10 non-owner gating
        wr(1, 2'd1, 32'h0000_00B7);
        wr(0, 2'd1, 32'hDEAD_BEEF);
        rd_reg(1, 2'd1, v); chk("R10 non-owner write ignored", v, 32'h0000_00B7);
        rd_reg(0, 2'd1, v); chk("R10 non-owner cmd read 0", v, 32'd0);
        sa = 32'h0000_3000;
        load_cmd(1, 8'hB7, sa);
        wr(1, 2'd0, 32'h8700_0000);
        repeat (10) @(negedge clk);
        rd_reg(0, 2'd3, v); chk("R10 non-owner data read 0", v, 32'd0);
        rd_reg(0, 2'd0, v); rd_reg(1, 2'd0, w2);
        chk("R10 mirrored control status", v, w2);
        rd_reg(1, 2'd3, v); chk("R10 owner word not consumed", v, rom_word(sa));
        rd_reg(1, 2'd0, v); chk("R6 owner drained block", {31'd0, v[31]}, 32'd0);

        set_cfg(16'h0800);
        run_block(0, 7, 8'hB7, 32'h0000_0040, "backA R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule